// File: doc/BRIEF.md
# Exception Vector and Status Control

This block keeps the privilege and exception-control bits of a processor status register. From them it works out the 64-bit virtual address where the pipeline must resume when an exception is accepted. Each cycle it looks at the requests present: a non-maskable interrupt, an exception tagged as a TLB miss or as general, and maskable interrupt lines. It grants the one with the highest priority. One clock edge later it shows a registered vector address together with a single-cycle taken strobe and a code for the kind of event.

A bootstrap bit picks either the bootstrap vector base or the normal vector base. Hardware sets this bit on reset and whenever an NMI is taken. There are three per-segment bits, one each for kernel, supervisor and user address segments. When the bit for the segment that missed is set, a TLB miss goes to an extended handler 0x080 above the ordinary miss vector. The same register also holds a global interrupt enable, a parity-exception mute and a parity-source select for the caches. The source select tells the caches to take stored parity instead of generated parity. A reverse-endian bit exists in the layout but is forced to zero.

Top module: `exc_vector_ctrl`

## Requirements
- R1: A synchronous reset gives status value 0x20, with only bit 5 (boot) set. The outputs exc_taken, exc_kind, vec_addr, irq_pend and par_exc all read 0 after reset. Reset outranks every other request.
- R2: A status write lands on the next clock edge. The field layout is: bit0 irq enable, bit1 kernel extended miss, bit2 supervisor extended miss, bit3 user extended miss, bit4 reverse endian, bit5 boot, bit6 stored-parity select, bit7 parity mute. Bit 4 always reads 0, whatever was written.
- R3: A taken NMI sets bit 5 on the same edge, even when a write in that cycle clears it. The NMI vector is 0xFFFFFFFF_BFC00000 and its kind code is 1.
- R4: With bit 5 set, the TLB miss vector is 0xFFFFFFFF_BFC00200. With bit 5 set, the general and interrupt vector is 0xFFFFFFFF_BFC00380.
- R5: With bit 5 clear, the TLB miss vector is 0xFFFFFFFF_80000000. With bit 5 clear, the general and interrupt vector is 0xFFFFFFFF_80000180.
- R6: A TLB miss is extended when the status bit for its miss_seg is set. The segment codes are 0 kernel (bit1), 1 supervisor (bit2), 2 user (bit3), and 3 reserved, treated as kernel. An extended miss uses the miss vector plus 0x080 and has kind code 3. A plain miss has code 2.
- R7: Priority runs NMI, then TLB miss (exc_req with exc_tlb), then general exception (exc_req alone, code 4), then maskable interrupt (code 5). Only one event is taken per cycle.
- R8: irq_pend is the registered value of bit0 AND any irq_req line. An interrupt is taken only when irq_pend would be set and no other request is present.
- R9: par_exc is the registered value of par_err_i AND NOT bit7.
- R10: use_stored_par equals status bit 6.
- R11: wide_addr_en is 1 in kernel mode (priv_mode 0). In supervisor mode (1) it follows bit 2. In user mode (2) it follows bit 3. For code 3 it is 0.
- R12: exc_taken, exc_kind and vec_addr are registered one cycle after the request. vec_addr reads 0 and exc_kind reads 0 in any cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 8 | Status write data |
| priv_mode | input | 2 | Current privilege: 0 kernel, 1 supervisor, 2 user |
| nmi_i | input | 1 | Non-maskable interrupt request |
| exc_req | input | 1 | Exception request |
| exc_tlb | input | 1 | Request is a TLB miss (else general) |
| miss_seg | input | 2 | Segment of the missing address |
| irq_req | input | NIRQ | Maskable interrupt lines |
| par_err_i | input | 1 | Cache parity error report |
| stat_rdata | output | 8 | Current status value |
| exc_taken | output | 1 | One-cycle accepted-event strobe |
| exc_kind | output | 3 | Kind of accepted event (0 none) |
| vec_addr | output | VA_W | Handler address, valid with the strobe |
| irq_pend | output | 1 | Unmasked interrupt pending |
| par_exc | output | 1 | Parity exception raised |
| use_stored_par | output | 1 | Caches take stored parity |
| wide_addr_en | output | 1 | 64-bit operation allowed in current mode |

## Verification
The hardest case to reach is an NMI that arrives in the same cycle as a status write clearing the boot bit, while TLB and interrupt requests are also present. There the write, the hardware set and the priority logic all act on one edge. Directed steps set up this collision, and also extended misses from every segment code under both vector bases. A long run of seeded random cycles then mixes writes, NMIs and request patterns. Each outcome is compared against a bench reference model of the status register.

// File: rtl/exv_pkg.sv
package exv_pkg;
  localparam int STAT_W = 8;
  localparam int ST_IE    = 0;
  localparam int ST_XK    = 1;
  localparam int ST_XS    = 2;
  localparam int ST_XU    = 3;
  localparam int ST_RE    = 4;
  localparam int ST_BOOT  = 5;
  localparam int ST_PSEL  = 6;
  localparam int ST_PMUTE = 7;
  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << ST_BOOT;
  localparam logic [STAT_W-1:0] RE_MASK  = STAT_W'(1) << ST_RE;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_NMI  = 3'd1,
    K_TLB  = 3'd2,
    K_XTLB = 3'd3,
    K_GEN  = 3'd4,
    K_IRQ  = 3'd5
  } exc_kind_e;
endpackage

// File: rtl/exv_status_reg.sv
module exv_status_reg
  import exv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [STAT_W-1:0] wdata,
  input  logic              nmi_take,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (we) stat_nxt = wdata;
    stat_nxt[ST_RE] = 1'b0;
    if (nmi_take) stat_nxt[ST_BOOT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= STAT_RST;
    else     stat_q <= stat_nxt;
  end

  a_r2_re_never_set: assert property (@(posedge clk) disable iff (rst)
    stat_q[ST_RE] == 1'b0);
  a_r3_nmi_sets_boot: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> stat_q[ST_BOOT]);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && !nmi_take) |=> (stat_q == ($past(wdata) & ~RE_MASK)));
endmodule

// File: rtl/exv_arbiter.sv
module exv_arbiter
  import exv_pkg::*;
(
  input  logic      nmi_i,
  input  logic      exc_req,
  input  logic      exc_tlb,
  input  logic      ext_hit,
  input  logic      irq_hit,
  output exc_kind_e kind,
  output logic      take
);
  logic g_nmi, g_tlb, g_gen, g_irq;

  always_comb begin
    g_nmi = nmi_i;
    g_tlb = !g_nmi && exc_req && exc_tlb;
    g_gen = !g_nmi && exc_req && !exc_tlb;
    g_irq = !g_nmi && !exc_req && irq_hit;
  end

  always_comb begin
    if (g_nmi)      kind = K_NMI;
    else if (g_tlb) kind = ext_hit ? K_XTLB : K_TLB;
    else if (g_gen) kind = K_GEN;
    else if (g_irq) kind = K_IRQ;
    else            kind = K_NONE;
    take = g_nmi | g_tlb | g_gen | g_irq;
  end

  always_comb begin
    a_r7_single_grant: assert ($onehot0({g_nmi, g_tlb, g_gen, g_irq}));
  end
endmodule

// File: rtl/exv_vector_gen.sv
module exv_vector_gen
  import exv_pkg::*;
#(
  parameter int VA_W = 64,
  parameter logic [VA_W-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [VA_W-1:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
  parameter int MISS_BOOT_OFF = 'h200,
  parameter int EXT_OFF = 'h080,
  parameter int GEN_OFF = 'h180
) (
  input  exc_kind_e       kind,
  input  logic            boot,
  input  logic [2:0]      ext_bits,
  input  logic [1:0]      seg,
  output logic            ext_hit,
  output logic [VA_W-1:0] addr
);
  localparam logic [VA_W-1:0] MISS_BOOT = BOOT_BASE + VA_W'(MISS_BOOT_OFF);
  localparam logic [VA_W-1:0] MISS_NORM = NORM_BASE;
  localparam int NSEG = 4;

  logic [NSEG-1:0] ext_by_seg;
  logic [VA_W-1:0] miss_base;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int SRC = (g == NSEG - 1) ? 0 : g;
    assign ext_by_seg[g] = ext_bits[SRC];
  end

  assign ext_hit   = ext_by_seg[seg];
  assign miss_base = boot ? MISS_BOOT : MISS_NORM;

  always_comb begin
    case (kind)
      K_NMI:        addr = BOOT_BASE;
      K_TLB:        addr = miss_base;
      K_XTLB:       addr = miss_base + VA_W'(EXT_OFF);
      K_GEN, K_IRQ: addr = miss_base + VA_W'(GEN_OFF);
      default:      addr = '0;
    endcase
  end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
  import exv_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int NIRQ = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic [1:0]        priv_mode,
  input  logic              nmi_i,
  input  logic              exc_req,
  input  logic              exc_tlb,
  input  logic [1:0]        miss_seg,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic              par_err_i,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              exc_taken,
  output logic [2:0]        exc_kind,
  output logic [VA_W-1:0]   vec_addr,
  output logic              irq_pend,
  output logic              par_exc,
  output logic              use_stored_par,
  output logic              wide_addr_en
);
  logic [STAT_W-1:0] stat_q;
  exc_kind_e         kind_c;
  logic              take_c, ext_hit, irq_hit;
  logic [VA_W-1:0]   addr_c;

  assign irq_hit = stat_q[ST_IE] & (|irq_req);

  exv_status_reg u_stat (
    .clk(clk), .rst(rst), .we(stat_we), .wdata(stat_wdata),
    .nmi_take(nmi_i), .stat_q(stat_q)
  );

  exv_arbiter u_arb (
    .nmi_i(nmi_i), .exc_req(exc_req), .exc_tlb(exc_tlb),
    .ext_hit(ext_hit), .irq_hit(irq_hit), .kind(kind_c), .take(take_c)
  );

  exv_vector_gen #(.VA_W(VA_W)) u_vec (
    .kind(kind_c), .boot(stat_q[ST_BOOT]),
    .ext_bits(stat_q[ST_XU:ST_XK]), .seg(miss_seg),
    .ext_hit(ext_hit), .addr(addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_taken <= 1'b0;
      exc_kind  <= K_NONE;
      vec_addr  <= '0;
      irq_pend  <= 1'b0;
      par_exc   <= 1'b0;
    end else begin
      exc_taken <= take_c;
      exc_kind  <= take_c ? kind_c : K_NONE;
      vec_addr  <= take_c ? addr_c : '0;
      irq_pend  <= irq_hit;
      par_exc   <= par_err_i & ~stat_q[ST_PMUTE];
    end
  end

  always_comb begin
    case (priv_mode)
      2'd0:    wide_addr_en = 1'b1;
      2'd1:    wide_addr_en = stat_q[ST_XS];
      2'd2:    wide_addr_en = stat_q[ST_XU];
      default: wide_addr_en = 1'b0;
    endcase
  end

  assign use_stored_par = stat_q[ST_PSEL];
  assign stat_rdata     = stat_q;

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !exc_taken |-> (vec_addr == '0 && exc_kind == 3'd0));
  a_r7_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    nmi_i |=> (exc_taken && exc_kind == 3'd1));
  a_r9_par_mute: assert property (@(posedge clk) disable iff (rst)
    par_exc |-> ($past(par_err_i) && !$past(stat_q[ST_PMUTE])));
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> $past(stat_q[ST_IE]));
endmodule

// File: tb/exc_vector_ctrl_tb_top.sv
module exc_vector_ctrl_tb_top;
  localparam int NIRQ = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_we = 0;
  logic [7:0] stat_wdata = 0;
  logic [1:0] priv_mode = 0;
  logic nmi_i = 0, exc_req = 0, exc_tlb = 0, par_err_i = 0;
  logic [1:0] miss_seg = 0;
  logic [NIRQ-1:0] irq_req = 0;
  logic [7:0] stat_rdata;
  logic exc_taken, irq_pend, par_exc, use_stored_par, wide_addr_en;
  logic [2:0] exc_kind;
  logic [63:0] vec_addr;

  int total = 0, bad = 0;
  logic [7:0] mdl = 8'h20;

  always #10 clk = ~clk;

  exc_vector_ctrl #(.VA_W(64), .NIRQ(NIRQ)) dut_i (
    .clk(clk), .rst(rst), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .priv_mode(priv_mode), .nmi_i(nmi_i), .exc_req(exc_req), .exc_tlb(exc_tlb),
    .miss_seg(miss_seg), .irq_req(irq_req), .par_err_i(par_err_i),
    .stat_rdata(stat_rdata), .exc_taken(exc_taken), .exc_kind(exc_kind),
    .vec_addr(vec_addr), .irq_pend(irq_pend), .par_exc(par_exc),
    .use_stored_par(use_stored_par), .wide_addr_en(wide_addr_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_kind(logic [7:0] s);
    logic ext;
    ext = (miss_seg == 2'd1) ? s[2] : (miss_seg == 2'd2) ? s[3] : s[1];
    if (nmi_i) return 3'd1;
    if (exc_req && exc_tlb) return ext ? 3'd3 : 3'd2;
    if (exc_req) return 3'd4;
    if (s[0] && |irq_req) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [63:0] exp_vec(logic [2:0] k, logic [7:0] s);
    logic [63:0] mb;
    mb = s[5] ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
    case (k)
      3'd1: return 64'hFFFF_FFFF_BFC0_0000;
      3'd2: return mb;
      3'd3: return mb + 64'h80;
      3'd4, 3'd5: return mb + 64'h180;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic exp_wide(logic [7:0] s);
    case (priv_mode)
      2'd0: return 1'b1;
      2'd1: return s[2];
      2'd2: return s[3];
      default: return 1'b0;
    endcase
  endfunction

  // Inputs are already driven (after a negedge); predict, cross the edge, compare.
  task automatic step();
    logic [2:0] k;
    logic [63:0] v;
    logic [7:0] nx;
    logic ip, pe;
    string vr;
    k  = exp_kind(mdl);
    v  = exp_vec(k, mdl);
    ip = mdl[0] & (|irq_req);
    pe = par_err_i & ~mdl[7];
    nx = stat_we ? stat_wdata : mdl;
    nx[4] = 1'b0;
    if (nmi_i) nx[5] = 1'b1;
    case (k)
      3'd1: vr = "R3";
      3'd3: vr = "R6";
      3'd0: vr = "R12";
      default: vr = mdl[5] ? "R4" : "R5";
    endcase
    @(negedge clk);
    mdl = nx;
    chk(stat_rdata == mdl, "R2 status", 64'(stat_rdata), 64'(mdl));
    chk(exc_taken == (k != 3'd0), "R12 strobe", 64'(exc_taken), 64'(k != 3'd0));
    chk(exc_kind == k, "R7 kind", 64'(exc_kind), 64'(k));
    chk(vec_addr == v, vr, vec_addr, v);
    chk(irq_pend == ip, "R8 irq_pend", 64'(irq_pend), 64'(ip));
    chk(par_exc == pe, "R9 par_exc", 64'(par_exc), 64'(pe));
    chk(use_stored_par == mdl[6], "R10 stored parity", 64'(use_stored_par), 64'(mdl[6]));
    chk(wide_addr_en == exp_wide(mdl), "R11 wide", 64'(wide_addr_en), 64'(exp_wide(mdl)));
  endtask

  task automatic idle();
    stat_we = 0; nmi_i = 0; exc_req = 0; exc_tlb = 0; irq_req = '0; par_err_i = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    idle(); stat_we = 1; stat_wdata = d; step(); idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(stat_rdata == 8'h20, "R1 status", 64'(stat_rdata), 64'h20);
    chk(!exc_taken && exc_kind == 0 && vec_addr == 0, "R1 outputs", vec_addr, 64'h0);
    chk(!irq_pend && !par_exc, "R1 flags", 64'({irq_pend, par_exc}), 64'h0);
    mdl = 8'h20;

    // R4: boot vectors, R6 extended in each segment
    wr(8'h2E);
    for (int s = 0; s < 4; s++) begin
      exc_req = 1; exc_tlb = 1; miss_seg = 2'(s); step(); idle();
    end
    exc_req = 1; step(); idle();
    // R5: normal vectors, no extension
    wr(8'h00);
    for (int s = 0; s < 4; s++) begin
      exc_req = 1; exc_tlb = 1; miss_seg = 2'(s); step(); idle();
    end
    exc_req = 1; step(); idle();
    // R6: only user extended under normal base
    wr(8'h08);
    for (int s = 0; s < 4; s++) begin
      exc_req = 1; exc_tlb = 1; miss_seg = 2'(s); step(); idle();
    end
    // R2: reverse-endian bit ignored
    wr(8'hFF);
    wr(8'h10);
    // R3: NMI collides with write clearing boot, with other requests present
    stat_we = 1; stat_wdata = 8'h01; nmi_i = 1; exc_req = 1; exc_tlb = 1; irq_req = 8'h80;
    step(); idle();
    // R8: interrupt taken when enabled, masked otherwise
    irq_req = 8'h04; step(); idle();
    wr(8'h00);
    irq_req = 8'hFF; step(); idle();
    // R9 / R10
    wr(8'h40); par_err_i = 1; step(); idle();
    wr(8'h80); par_err_i = 1; step(); idle();
    // R11 over all privilege codes
    for (int p = 0; p < 4; p++) begin
      priv_mode = 2'(p); wr(8'h04); wr(8'h08);
    end

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      stat_we    = ($urandom % 4) == 0;
      stat_wdata = 8'($urandom);
      nmi_i      = ($urandom % 16) == 0;
      exc_req    = ($urandom % 3) == 0;
      exc_tlb    = 1'($urandom);
      miss_seg   = 2'($urandom);
      irq_req    = (($urandom % 2) == 0) ? 8'($urandom) : 8'h0;
      par_err_i  = 1'($urandom);
      priv_mode  = 2'($urandom);
      step();
    end
    idle();
    // R1: reset mid-run
    rst = 1; @(negedge clk); rst = 0;
    mdl = 8'h20;
    chk(stat_rdata == 8'h20, "R1 re-reset", 64'(stat_rdata), 64'h20);
    chk(!exc_taken, "R1 re-reset strobe", 64'(exc_taken), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule